// File: doc/BRIEF.md
# Dual-Buffer Page Compare Engine

This engine models the internal page operations of a small serial flash device. A front end that has already decoded the serial stream passes it a single-cycle command when chip select returns high. The command carries an operation, a buffer select and a page number. The engine then works through the page one byte per clock. It can copy a main-memory page into one of two page buffers, compare a page with a buffer, or copy a page into a buffer and program it straight back.

An 8-bit status byte can be read at any time. It shows a ready flag and the result of the most recent compare. The main memory and both buffers are small on-chip arrays. Direct byte write ports preload them, and combinational read ports observe them. Both write ports are locked out while an operation runs. PAGE_BYTES and PAGES must be powers of two.

Top module: `page_cmp_engine`

## Requirements
- R1: After reset the status byte reads 8'h80: ready, compare bit clear, and all other bits zero.
- R2: Command code 2'b01 (transfer) copies every byte of page cmd_page into the buffer chosen by cmd_buf. It keeps the engine busy for exactly PAGE_BYTES clock cycles.
- R3: Command code 2'b10 (compare) checks every byte of the page against the chosen buffer. It always takes exactly PAGE_BYTES busy cycles, with no early exit. It modifies neither the memory nor the buffers.
- R4: Status bit 6 is written only when a compare finishes: 0 when all bytes match and 1 on any mismatch. Transfers and rewrites leave it unchanged.
- R5: Command code 2'b11 (rewrite) first loads the page into the chosen buffer and then programs that buffer back into the same page. Both steps run under one busy window of 2*PAGE_BYTES cycles.
- R6: Status bit 7 reads 0 while an operation runs and 1 otherwise. Status bits 5 to 0 always read 0.
- R7: A command that arrives while busy is dropped. A command with code 2'b00 starts nothing.
- R8: Direct writes to a buffer or to main memory are ignored while the engine is busy.
- R9: The two buffers are independent. An operation on one buffer never alters the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe, raised when chip select rises |
| cmd_op | input | 2 | Operation: 01 transfer, 10 compare, 11 rewrite, 00 none |
| cmd_buf | input | 1 | Buffer select |
| cmd_page | input | $clog2(PAGES) | Page number |
| buf_wr_en | input | 1 | Direct buffer byte write strobe |
| buf_wr_sel | input | 1 | Buffer written |
| buf_wr_idx | input | $clog2(PAGE_BYTES) | Byte index written |
| buf_wr_data | input | DATA_W | Byte written |
| mem_wr_en | input | 1 | Direct main-memory byte write strobe |
| mem_wr_addr | input | $clog2(PAGES*PAGE_BYTES) | Memory byte address {page, index} |
| mem_wr_data | input | DATA_W | Byte written |
| buf_rd_sel | input | 1 | Buffer read |
| buf_rd_idx | input | $clog2(PAGE_BYTES) | Byte index read |
| buf_rd_data | output | DATA_W | Buffer byte, combinational |
| mem_rd_addr | input | $clog2(PAGES*PAGE_BYTES) | Memory byte address read |
| mem_rd_data | output | DATA_W | Memory byte, combinational |
| status_o | output | 8 | {ready, compare mismatch, 6'b0} |

## Verification
The assertions assume that the command strobe is a clean single-cycle pulse with its operation fields stable in that cycle. They also assume that the direct write ports are driven only with in-range addresses. The bench holds every strobe for exactly one cycle. It changes inputs only on falling edges and keeps all addresses inside the configured page and memory size. Some stimulus deliberately breaks the engine's own protocol, such as commands and direct writes during a busy window, because that behaviour belongs to the requirements.

// File: rtl/page_cmp_engine.sv
module page_cmp_engine #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int PAGES      = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = $clog2(PAGES),
  localparam int MEM_AW    = PG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_buf,
  input  logic [PG_W-1:0]   cmd_page,
  input  logic              buf_wr_en,
  input  logic              buf_wr_sel,
  input  logic [IDX_W-1:0]  buf_wr_idx,
  input  logic [DATA_W-1:0] buf_wr_data,
  input  logic              mem_wr_en,
  input  logic [MEM_AW-1:0] mem_wr_addr,
  input  logic [DATA_W-1:0] mem_wr_data,
  input  logic              buf_rd_sel,
  input  logic [IDX_W-1:0]  buf_rd_idx,
  output logic [DATA_W-1:0] buf_rd_data,
  input  logic [MEM_AW-1:0] mem_rd_addr,
  output logic [DATA_W-1:0] mem_rd_data,
  output logic [7:0]        status_o
);

  localparam int MEM_BYTES = PAGES * PAGE_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_CMP, S_PROG} state_t;

  state_t            state_q;
  logic [1:0]        op_q;
  logic              sel_q;
  logic [PG_W-1:0]   page_q;
  logic [IDX_W-1:0]  idx_q;
  logic              diff_q;
  logic              cmp_q;

  logic [DATA_W-1:0] mem_q [MEM_BYTES];
  logic [DATA_W-1:0] buf_q [2][PAGE_BYTES];

  wire               busy    = (state_q != S_IDLE);
  wire               last    = (idx_q == IDX_W'(PAGE_BYTES - 1));
  wire  [MEM_AW-1:0] cur_adr = {page_q, idx_q};
  wire               neq     = (mem_q[cur_adr] != buf_q[sel_q][idx_q]);
  wire               accept  = !busy && cmd_valid && (cmd_op != 2'b00);

  assign status_o    = {~busy, cmp_q, 6'b0};
  assign buf_rd_data = buf_q[buf_rd_sel][buf_rd_idx];
  assign mem_rd_data = mem_q[mem_rd_addr];

  always_ff @(posedge clk) begin
    if (state_q == S_PROG)
      mem_q[cur_adr] <= buf_q[sel_q][idx_q];
    else if (!busy && mem_wr_en)
      mem_q[mem_wr_addr] <= mem_wr_data;
    if (state_q == S_XFER)
      buf_q[sel_q][idx_q] <= mem_q[cur_adr];
    else if (!busy && buf_wr_en)
      buf_q[buf_wr_sel][buf_wr_idx] <= buf_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= 2'b00;
      sel_q   <= 1'b0;
      page_q  <= '0;
      idx_q   <= '0;
      diff_q  <= 1'b0;
      cmp_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          op_q    <= cmd_op;
          sel_q   <= cmd_buf;
          page_q  <= cmd_page;
          idx_q   <= '0;
          diff_q  <= 1'b0;
          state_q <= (cmd_op == 2'b10) ? S_CMP : S_XFER;
        end
        S_XFER: begin
          idx_q <= idx_q + 1'b1;
          if (last) state_q <= (op_q == 2'b11) ? S_PROG : S_IDLE;
        end
        S_CMP: begin
          idx_q  <= idx_q + 1'b1;
          diff_q <= diff_q | neq;
          if (last) begin
            cmp_q   <= diff_q | neq;
            state_q <= S_IDLE;
          end
        end
        S_PROG: begin
          idx_q <= idx_q + 1'b1;
          if (last) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r7_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op != 2'b00) |=> !status_o[7]);

  a_r7_busy_cmd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(page_q) && $stable(sel_q) && $stable(op_q)));

  a_r4_bit6_only_after_compare: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o[6]) |-> ($past(state_q) == S_CMP));

  a_r8_mem_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_wr_en && state_q != S_PROG)
      |=> (mem_q[$past(mem_wr_addr)] == $past(mem_q[mem_wr_addr])));

  a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5:0] == 6'b0);

endmodule

// File: tb/test_page_cmp_engine.sv
module test_page_cmp_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 8;
  localparam int NP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic       cmd_buf = 0;
  logic [2:0] cmd_page = 0;
  logic       buf_wr_en = 0, buf_wr_sel = 0;
  logic [2:0] buf_wr_idx = 0;
  logic [7:0] buf_wr_data = 0;
  logic       mem_wr_en = 0;
  logic [5:0] mem_wr_addr = 0;
  logic [7:0] mem_wr_data = 0;
  logic       buf_rd_sel = 0;
  logic [2:0] buf_rd_idx = 0;
  logic [7:0] buf_rd_data;
  logic [5:0] mem_rd_addr = 0;
  logic [7:0] mem_rd_data;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  int busy_cnt = 0;
  int    exp_len_q[$];
  logic  exp_b6_q[$];
  string exp_req_q[$];
  logic [7:0] mdl_mem [NP*PB];
  logic [7:0] mdl_buf [2][PB];

  page_cmp_engine i_page_cmp_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_buf(cmd_buf), .cmd_page(cmd_page), .buf_wr_en(buf_wr_en),
    .buf_wr_sel(buf_wr_sel), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .buf_rd_sel(buf_rd_sel), .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .status_o(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) busy_cnt = 0;
    else if (status[7] === 1'b0) busy_cnt++;
    else if (busy_cnt > 0) begin
      if (exp_len_q.size() == 0) check("R7 unexpected busy window", busy_cnt, 0);
      else begin
        string r;
        r = exp_req_q.pop_front();
        check({r, " busy length"}, busy_cnt, exp_len_q.pop_front());
        check({r, " status bit6"}, int'(status[6]), int'(exp_b6_q.pop_front()));
      end
      busy_cnt = 0;
    end
  end

  task automatic push_exp(input int len, input logic b6, input string req);
    exp_len_q.push_back(len);
    exp_b6_q.push_back(b6);
    exp_req_q.push_back(req);
  endtask

  task automatic wait_ready();
    while (status[7] !== 1'b1) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic sel, input int pg,
                         input int len, input logic b6, input string req);
    push_exp(len, b6, req);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_buf = sel; cmd_page = 3'(pg);
    @(negedge clk);
    cmd_valid = 0;
    wait_ready();
    @(negedge clk);
  endtask

  task automatic write_buf(input logic sel, input int idx, input logic [7:0] d);
    @(negedge clk);
    buf_wr_en = 1; buf_wr_sel = sel; buf_wr_idx = 3'(idx); buf_wr_data = d;
    @(negedge clk);
    buf_wr_en = 0;
    mdl_buf[sel][idx] = d;
  endtask

  task automatic chk_buf(input logic sel, input string req);
    for (int i = 0; i < PB; i++) begin
      buf_rd_sel = sel; buf_rd_idx = 3'(i); #1;
      check(req, buf_rd_data, mdl_buf[sel][i]);
    end
  endtask

  task automatic chk_page(input int pg, input string req);
    for (int i = 0; i < PB; i++) begin
      mem_rd_addr = 6'(pg*PB + i); #1;
      check(req, mem_rd_data, mdl_mem[pg*PB + i]);
    end
  endtask

  function automatic logic cmp_model(input int pg, input logic sel);
    logic d = 0;
    for (int i = 0; i < PB; i++) if (mdl_mem[pg*PB+i] != mdl_buf[sel][i]) d = 1;
    return d;
  endfunction

  task automatic xfer_model(input int pg, input logic sel);
    for (int i = 0; i < PB; i++) mdl_buf[sel][i] = mdl_mem[pg*PB+i];
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic b6;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", status, 8'h80);

    for (int a = 0; a < NP*PB; a++) begin
      @(negedge clk);
      mem_wr_en = 1; mem_wr_addr = 6'(a); mem_wr_data = 8'(a*37 + 11);
      mdl_mem[a] = 8'(a*37 + 11);
    end
    @(negedge clk); mem_wr_en = 0;
    for (int i = 0; i < PB; i++) begin
      write_buf(0, i, mdl_mem[2*PB+i]);
      write_buf(1, i, 8'(i*5 + 200));
    end
    chk_page(2, "R8 idle memory write");

    // R3 match
    run_cmd(2'b10, 0, 2, PB, 0, "R3 compare match");
    chk_buf(0, "R3 compare leaves buffer");
    // R3 mismatch
    b6 = cmp_model(3, 1);
    run_cmd(2'b10, 1, 3, PB, b6, "R3 compare mismatch");
    check("R3 expect mismatch", int'(status[6]), 1);

    // R2 transfer, R4 bit6 kept, R9 other buffer untouched
    xfer_model(5, 1);
    run_cmd(2'b01, 1, 5, PB, 1, "R4 transfer keeps bit6");
    chk_buf(1, "R2 transfer content");
    chk_buf(0, "R9 other buffer");
    check("R6 ready status", status, 8'hC0);
    run_cmd(2'b10, 1, 5, PB, 0, "R3 compare after transfer");

    // mismatch only on last byte, then only on first byte
    write_buf(0, PB-1, ~mdl_buf[0][PB-1]);
    run_cmd(2'b10, 0, 2, PB, 1, "R3 last byte mismatch");
    write_buf(0, PB-1, mdl_mem[2*PB+PB-1]);
    write_buf(0, 0, ~mdl_buf[0][0]);
    run_cmd(2'b10, 0, 2, PB, 1, "R3 first byte mismatch no early exit");

    // R5 rewrite
    xfer_model(6, 0);
    run_cmd(2'b11, 0, 6, 2*PB, 1, "R5 rewrite window");
    chk_buf(0, "R5 rewrite buffer");
    chk_page(6, "R5 rewrite page");
    chk_buf(1, "R9 rewrite other buffer");

    // R7 op 00 ignored
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b00; cmd_buf = 1; cmd_page = 3'd0;
    @(negedge clk);
    cmd_valid = 0;
    check("R7 null op stays ready", status, 8'hC0);
    chk_buf(1, "R7 null op buffer");

    // R7 drop while busy, R8 writes locked while busy
    push_exp(PB, 1, "R7 busy drop window");
    xfer_model(1, 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b01; cmd_buf = 0; cmd_page = 3'd1;
    @(negedge clk);
    check("R6 busy status", status, 8'h40);
    cmd_op = 2'b01; cmd_buf = 1; cmd_page = 3'd7;
    mem_wr_en = 1; mem_wr_addr = 6'd0; mem_wr_data = ~mdl_mem[0];
    buf_wr_en = 1; buf_wr_sel = 1; buf_wr_idx = 3'd0; buf_wr_data = ~mdl_buf[1][0];
    @(negedge clk);
    cmd_valid = 0; mem_wr_en = 0; buf_wr_en = 0;
    wait_ready();
    @(negedge clk);
    chk_buf(0, "R2 transfer page1");
    chk_buf(1, "R7 dropped command buffer");
    chk_page(0, "R8 locked memory write");

    b6 = cmp_model(7, 1);
    run_cmd(2'b10, 1, 7, PB, b6, "R3 compare page7");

    repeat (3) @(negedge clk);
    check("R7 all windows seen", exp_len_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule